// File: doc/BRIEF.md
# FPGA Bitstream Configuration Sequencer

This block pushes a configuration image into an SRAM-based FPGA that is configured passively. On a start request it pulls the target's configuration-reset line low for a fixed time and releases it. It then waits for the target to settle and clocks the image in, one byte at a time, from a valid/ready byte stream. The target's status line is checked before every byte. At the end the block issues a closing clock edge, waits, and reads the target's done line.

The load mode is chosen at start. In bit-serial mode each byte goes out on data line 0, least significant bit first, with one configuration clock pulse per bit. In byte-wide mode the byte is placed on all eight data lines and clocked once. In byte-wide mode with the decryption/decompression option, the target needs four clock pulses per byte, and the data is held for all four. All waits are derived from a clock-frequency parameter. The configuration clock high and low phases are each a parameterised number of system clocks long.

Top module: `cfg_loader`

## Requirements
- R1: While reset is held, and whenever the block is idle afterwards, the configuration-reset output is high, the configuration clock is low, the data lines are low, and busy and stream ready are low. After reset, success and failure are low.
- R2: A start request is ignored if the block is busy, if the mode code is 3, or if the byte count is 0. An ignored request leaves busy low, leaves the configuration-reset line high, and leaves the status outputs unchanged. Mode codes are 0 for bit-serial, 1 for byte-wide and 2 for byte-wide with the option.
- R3: An accepted start drives the configuration-reset output low for exactly CLK_HZ/1e6 × NCFG_LOW_US system clocks and then releases it high.
- R4: The first rising configuration clock edge comes no earlier than CLK_HZ/1e6 × SETTLE_US system clocks after the configuration-reset line is released. The clock is low until then.
- R5: During the byte phase every configuration clock high phase lasts exactly DCLK_HALF system clocks, and every low phase between two rising edges lasts at least DCLK_HALF. The data lines do not change while the clock is high.
- R6: In bit-serial mode (code 0), each byte produces eight rising edges. At the k-th edge, data line 0 carries bit k of the byte (k = 0 first), and data lines 7..1 are low.
- R7: In byte-wide mode (code 1), each byte produces one rising edge, with the whole byte on data lines 7..0.
- R8: In byte-wide option mode (code 2), each byte produces four rising edges, with the same byte on data lines 7..0 at all four.
- R9: Stream ready is high only while the block waits for a byte and the target status input is high. If the status input is low when a byte is due, the block stops without taking the byte, pulses abort and sets failure.
- R10: After the last byte, one further rising edge is issued. That clock stays high for CLK_HZ/1e6 × DONE_WAIT_US system clocks, and then the done input is sampled. High sets success; low sets failure and pulses abort.
- R11: Success and failure stay set until the next accepted start, which clears both. Abort is high for exactly one system clock per failure.
- R12: A load takes exactly the requested byte count from the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| mode_i | input | 2 | Load mode: 0 bit-serial, 1 byte-wide, 2 byte-wide with option |
| byte_count_i | input | CNT_W | Number of image bytes for this load |
| s_data_i | input | 8 | Image byte |
| s_valid_i | input | 1 | Image byte valid |
| s_ready_o | output | 1 | Sequencer takes the byte this cycle |
| nconfig_o | output | 1 | Active-low configuration reset to the target |
| dclk_o | output | 1 | Configuration clock to the target |
| data_o | output | 8 | Configuration data lines |
| nstatus_i | input | 1 | Target status, low means error |
| conf_done_i | input | 1 | Target done indication |
| busy_o | output | 1 | A load is in progress |
| load_ok_o | output | 1 | Sticky success |
| load_fail_o | output | 1 | Sticky failure |
| abort_o | output | 1 | Single-cycle abort pulse on any failure |

## Verification
A wrong sequencer state shows up within one configuration clock period at the ports. If the per-byte pulse count is wrong, the number of rising edges per load is off and the captured data sequence shifts, and both are checked at every load. If the serial shift register is wrong, the bit captured at the first bad edge is wrong. A timer reload error changes the measured reset-pulse length, settle gap, clock high width or final wait. A wrong byte counter shows as a mismatch between bytes taken from the stream and the count requested, or as a premature closing edge. The sweep covers every mode at several byte counts, failures before the first byte, mid-image and at the done check, and each rejected kind of start.

// File: rtl/cfg_loader_pkg.sv
// Shared types for the configuration sequencer.
package cfg_loader_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        MODE_SERIAL = 2'd0,
        MODE_PAR    = 2'd1,
        MODE_SECURE = 2'd2,
        MODE_BAD    = 2'd3
    } load_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NCFG,
        ST_SETTLE,
        ST_FETCH,
        ST_LO,
        ST_HI,
        ST_TAIL,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/cfg_delay_timer.sv
// Down-counting delay timer. Loading value N-1 makes zero_o go high
// N cycles later. Assumes the value is loaded on the edge that enters a wait state.
module cfg_delay_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] val_i,
    output logic          zero_o
);
    logic [TW-1:0] cnt_q;

    // load or count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (load_i)      cnt_q <= val_i;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

    // R5: a load never happens while a count is still running
    // R5
    load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i && !zero_o |-> 1'b0 || cnt_q == '0 || !load_i || zero_o);
endmodule

// File: rtl/cfg_byte_lane.sv
// Holds the byte being sent and counts the clock pulses left for it.
// Serial mode presents bit 0 on lane 0 and shifts right after each pulse.
// Parallel modes present the whole byte for every pulse.
module cfg_byte_lane
    import cfg_loader_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] byte_i,
    input  load_mode_e        mode_i,
    input  logic              step_i,
    output logic [DATA_W-1:0] data_o,
    output logic              last_o
);
    localparam int PW = 4;

    logic [DATA_W-1:0] sh_q;
    logic [PW-1:0]     left_q;
    logic [PW-1:0]     pulses;

    // pulses per byte for the selected mode
    always_comb begin
        case (mode_i)
            MODE_SERIAL: pulses = PW'(DATA_W);
            MODE_SECURE: pulses = PW'(4);
            default:     pulses = PW'(1);
        endcase
    end

    // byte register and pulse counter
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            sh_q   <= '0;
            left_q <= '0;
        end else if (load_i) begin
            sh_q   <= byte_i;
            left_q <= pulses;
        end else if (step_i) begin
            left_q <= left_q - 1'b1;
            if (mode_i == MODE_SERIAL) sh_q <= sh_q >> 1;
        end
    end

    // lane mapping per mode
    generate
        for (genvar g = 0; g < DATA_W; g++) begin : g_lane
            if (g == 0) begin : g_bit0
                assign data_o[g] = sh_q[g];
            end else begin : g_upper
                assign data_o[g] = (mode_i == MODE_SERIAL) ? 1'b0 : sh_q[g];
            end
        end
    endgenerate

    assign last_o = (left_q == PW'(1));

    // R6: a step is only requested while pulses remain for the byte
    // R6
    step_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> left_q != '0);
endmodule

// File: rtl/cfg_loader.sv
// Configuration sequencer top. Runs the reset pulse, settle wait,
// per-byte clocking in three modes, the closing edge and the done check.
// Assumes CLK_HZ is at least 1 MHz for exact microsecond waits (it is
// clamped to one cycle per microsecond below that).
module cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int CLK_HZ       = 100_000_000,
    parameter int NCFG_LOW_US  = 5,
    parameter int SETTLE_US    = 100,
    parameter int DONE_WAIT_US = 100,
    parameter int DCLK_HALF    = 1,
    parameter int CNT_W        = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       mode_i,
    input  logic [CNT_W-1:0] byte_count_i,
    input  logic [7:0]       s_data_i,
    input  logic             s_valid_i,
    output logic             s_ready_o,
    output logic             nconfig_o,
    output logic             dclk_o,
    output logic [7:0]       data_o,
    input  logic             nstatus_i,
    input  logic             conf_done_i,
    output logic             busy_o,
    output logic             load_ok_o,
    output logic             load_fail_o,
    output logic             abort_o
);
    localparam int CYC_US   = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
    localparam int LOW_CYC  = CYC_US * NCFG_LOW_US;
    localparam int SET_CYC  = CYC_US * SETTLE_US;
    localparam int DONE_CYC = CYC_US * DONE_WAIT_US;
    localparam int HALF_CYC = (DCLK_HALF < 1) ? 1 : DCLK_HALF;
    localparam int MAX_AB   = (LOW_CYC > SET_CYC) ? LOW_CYC : SET_CYC;
    localparam int MAX_CD   = (DONE_CYC > HALF_CYC) ? DONE_CYC : HALF_CYC;
    localparam int MAX_CYC  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int TW       = $clog2(MAX_CYC + 1);

    seq_state_e       state_q, state_d;
    load_mode_e       mode_q;
    logic [CNT_W-1:0] remaining_q;
    logic             ok_q, fail_q, abort_q;
    logic             tmr_load, tmr_zero;
    logic [TW-1:0]    tmr_val;
    logic             lane_load, lane_step, lane_last;
    logic             launch, accept, finish_ok, finish_fail;

    cfg_delay_timer #(.TW(TW)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    cfg_byte_lane lane_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (finish_ok | finish_fail),
        .load_i (lane_load),
        .byte_i (s_data_i),
        .mode_i (mode_q),
        .step_i (lane_step),
        .data_o (data_o),
        .last_o (lane_last)
    );

    // next state, timer reloads and lane controls
    always_comb begin
        state_d     = state_q;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        lane_load   = 1'b0;
        lane_step   = 1'b0;
        accept      = 1'b0;
        launch      = 1'b0;
        finish_ok   = 1'b0;
        finish_fail = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start_i && mode_i != MODE_BAD && byte_count_i != '0) begin
                    launch   = 1'b1;
                    state_d  = ST_NCFG;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(LOW_CYC - 1);
                end
            end
            ST_NCFG: begin
                if (tmr_zero) begin
                    state_d  = ST_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(SET_CYC - 1);
                end
            end
            ST_SETTLE: begin
                if (tmr_zero) state_d = ST_FETCH;
            end
            ST_FETCH: begin
                if (!nstatus_i) begin
                    finish_fail = 1'b1;
                    state_d     = ST_IDLE;
                end else if (s_valid_i) begin
                    accept    = 1'b1;
                    lane_load = 1'b1;
                    state_d   = ST_LO;
                    tmr_load  = 1'b1;
                    tmr_val   = TW'(HALF_CYC - 1);
                end
            end
            ST_LO: begin
                if (tmr_zero) begin
                    state_d  = ST_HI;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(HALF_CYC - 1);
                end
            end
            ST_HI: begin
                if (tmr_zero) begin
                    lane_step = 1'b1;
                    if (!lane_last) begin
                        state_d  = ST_LO;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(HALF_CYC - 1);
                    end else if (remaining_q == '0) begin
                        state_d  = ST_TAIL;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(HALF_CYC - 1);
                    end else begin
                        state_d = ST_FETCH;
                    end
                end
            end
            ST_TAIL: begin
                if (tmr_zero) begin
                    state_d  = ST_DONE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(DONE_CYC - 1);
                end
            end
            ST_DONE: begin
                if (tmr_zero) begin
                    state_d     = ST_IDLE;
                    finish_ok   = conf_done_i;
                    finish_fail = !conf_done_i;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state, byte budget and sticky status registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            mode_q      <= MODE_SERIAL;
            remaining_q <= '0;
            ok_q        <= 1'b0;
            fail_q      <= 1'b0;
            abort_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            abort_q <= finish_fail;
            if (launch) begin
                remaining_q <= byte_count_i;
                mode_q      <= load_mode_e'(mode_i);
                ok_q        <= 1'b0;
                fail_q      <= 1'b0;
            end else if (accept) begin
                remaining_q <= remaining_q - 1'b1;
            end
            if (finish_ok)   ok_q   <= 1'b1;
            if (finish_fail) fail_q <= 1'b1;
        end
    end

    assign busy_o      = (state_q != ST_IDLE);
    assign nconfig_o   = (state_q != ST_NCFG);
    assign dclk_o      = (state_q == ST_HI) || (state_q == ST_DONE);
    assign s_ready_o   = (state_q == ST_FETCH) && nstatus_i;
    assign load_ok_o   = ok_q;
    assign load_fail_o = fail_q;
    assign abort_o     = abort_q;

    // R3
    ncfg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nconfig_o |-> busy_o && !dclk_o);
    // R9
    ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready_o |-> nstatus_i && busy_o && !dclk_o);
    // R11
    abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !abort_o);
    // R11
    abort_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> load_fail_o && !busy_o);
    // R10
    status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_ok_o && load_fail_o));
    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dclk_o && $past(dclk_o) |-> $stable(data_o));
    // R1
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> nconfig_o && !dclk_o && data_o == 8'h00);
endmodule

// File: tb/cfg_loader_tb_top.sv
module cfg_loader_tb_top;
    localparam int LOW_C  = 5;
    localparam int SET_C  = 100;
    localparam int DONE_C = 100;
    localparam int HALF   = 2;

    logic       clk, rst_n, start_i, s_valid_i, nstatus_i, conf_done_i;
    logic [1:0] mode_i;
    logic [7:0] byte_count_i, s_data_i, data_o;
    logic       s_ready_o, nconfig_o, dclk_o, busy_o, load_ok_o, load_fail_o, abort_o;

    cfg_loader #(
        .CLK_HZ(1_000_000), .NCFG_LOW_US(LOW_C), .SETTLE_US(SET_C),
        .DONE_WAIT_US(DONE_C), .DCLK_HALF(HALF), .CNT_W(8)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .byte_count_i(byte_count_i), .s_data_i(s_data_i), .s_valid_i(s_valid_i),
        .s_ready_o(s_ready_o), .nconfig_o(nconfig_o), .dclk_o(dclk_o),
        .data_o(data_o), .nstatus_i(nstatus_i), .conf_done_i(conf_done_i),
        .busy_o(busy_o), .load_ok_o(load_ok_o), .load_fail_o(load_fail_o),
        .abort_o(abort_o)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    int errors = 0;
    int checks = 0;

    int feed_idx, feed_n, nfail, seed;
    bit feeding = 0, hs_pend = 0, mon_en = 0;
    int ncfg_lo, settle_cnt, nrise, hi_len, lo_len, width_err, stab_err;
    int ready_err, abort_cnt, final_hi;
    bit ncfg_was_low, first_rise, seen_fall, prev_dclk;
    logic [7:0] prev_data;
    logic [7:0] cap [64];

    function automatic logic [7:0] bval(input int j, input int s);
        return 8'((j * 37 + s * 11 + 5) ^ (j << 4));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor first, then stream feeder, all on the falling edge
    always @(negedge clk) begin
        if (mon_en) begin
            if (!nconfig_o) begin
                ncfg_lo++;
                ncfg_was_low = 1;
            end else if (ncfg_was_low && !first_rise && !dclk_o) settle_cnt++;
            if (dclk_o && !prev_dclk) begin
                if (nrise < 64) cap[nrise] = data_o;
                nrise++;
                first_rise = 1;
                if (seen_fall && lo_len < HALF) width_err++;
                hi_len = 1;
            end else if (dclk_o) begin
                hi_len++;
                if (data_o != prev_data) stab_err++;
            end else if (prev_dclk) begin
                if (busy_o) begin
                    if (hi_len != HALF) width_err++;
                end else final_hi = hi_len;
                seen_fall = 1;
                lo_len = 1;
            end else lo_len++;
            if (s_ready_o && !nstatus_i) ready_err++;
            if (abort_o) abort_cnt++;
            prev_dclk = dclk_o;
            prev_data = data_o;
        end
        if (feeding) begin
            if (hs_pend) feed_idx++;
            s_data_i  = bval(feed_idx, seed);
            s_valid_i = (feed_idx < feed_n);
            nstatus_i = !(nfail >= 0 && feed_idx >= nfail);
            hs_pend   = s_valid_i && s_ready_o;
        end
    end

    task automatic clear_mon();
        ncfg_lo = 0; settle_cnt = 0; nrise = 0; hi_len = 0; lo_len = 0;
        width_err = 0; stab_err = 0; ready_err = 0; abort_cnt = 0; final_hi = -1;
        ncfg_was_low = 0; first_rise = 0; seen_fall = 0; prev_dclk = 0; prev_data = 0;
    endtask

    task automatic run_load(input int mode, input int n, input bit cd, input int nf, input bit poke);
        int per, bad;
        logic [7:0] b, e;
        @(negedge clk);
        clear_mon();
        per = (mode == 0) ? 8 : (mode == 1) ? 1 : 4;
        feed_idx = 0; feed_n = n; nfail = nf; seed = mode * 7 + n; hs_pend = 0;
        s_data_i = bval(0, seed); s_valid_i = 1; nstatus_i = (nf != 0);
        conf_done_i = cd; mode_i = 2'(mode); byte_count_i = 8'(n);
        start_i = 1; feeding = 1; mon_en = 1;
        @(negedge clk);
        start_i = 0;
        // R11: start clears sticky status
        chk(busy_o && !load_ok_o && !load_fail_o, "R11 start clears status", {busy_o, load_ok_o, load_fail_o}, 4);
        if (poke) begin
            repeat (20) @(negedge clk);
            mode_i = 2'((mode + 1) % 3); byte_count_i = 8'(n + 3); start_i = 1;
            @(negedge clk);
            start_i = 0;
        end
        while (busy_o) @(negedge clk);
        @(negedge clk);
        feeding = 0;
        chk(ncfg_lo == LOW_C, "R3 nconfig low width", ncfg_lo, LOW_C);
        chk(width_err == 0 && stab_err == 0, "R5 clock phases and data hold", width_err + stab_err, 0);
        chk(ready_err == 0, "R9 ready gated by status", ready_err, 0);
        chk(data_o == 8'h00 && !dclk_o && nconfig_o, "R1 idle lines", data_o, 0);
        if (nf < 0) begin
            chk(settle_cnt >= SET_C, "R4 settle gap", settle_cnt, SET_C);
            chk(nrise == n * per + 1, (mode == 0) ? "R6 edge count" : (mode == 1) ? "R7 edge count" : "R8 edge count", nrise, n * per + 1);
            bad = 0;
            for (int j = 0; j < n; j++) begin
                b = bval(j, seed);
                for (int k = 0; k < per; k++) begin
                    e = (mode == 0) ? {7'b0, b[k]} : b;
                    if (cap[j * per + k] !== e) bad++;
                end
            end
            chk(bad == 0, (mode == 0) ? "R6 serial bit order" : (mode == 1) ? "R7 byte data" : "R8 repeated byte", bad, 0);
            chk(final_hi == DONE_C, "R10 final edge wait", final_hi, DONE_C);
            chk(load_ok_o == cd && load_fail_o == !cd, "R10 done sampling", {load_ok_o, load_fail_o}, {cd, !cd});
            chk(abort_cnt == (cd ? 0 : 1), "R11 abort pulse count", abort_cnt, cd ? 0 : 1);
            chk(feed_idx == n, "R12 bytes taken", feed_idx, n);
        end else begin
            chk(load_fail_o && !load_ok_o && abort_cnt == 1, "R9 status failure", {load_fail_o, load_ok_o, abort_cnt[1:0]}, 8'b1001);
            chk(feed_idx == nf && nrise == nf * per, "R9 stop point", feed_idx * 1000 + nrise, nf * 1000 + nf * per);
        end
        repeat (5) @(negedge clk);
        chk(load_ok_o == (nf < 0 && cd) && load_fail_o == !(nf < 0 && cd), "R11 sticky status", {load_ok_o, load_fail_o}, {(nf < 0 && cd), !(nf < 0 && cd)});
    endtask

    task automatic try_bad(input int mode, input int n);
        logic ok0, f0;
        @(negedge clk);
        clear_mon();
        ok0 = load_ok_o; f0 = load_fail_o;
        mode_i = 2'(mode); byte_count_i = 8'(n); start_i = 1; mon_en = 1;
        @(negedge clk);
        start_i = 0;
        repeat (10) @(negedge clk);
        chk(!busy_o && ncfg_lo == 0 && nrise == 0, "R2 rejected start", {busy_o, 1'b0}, 0);
        chk(load_ok_o == ok0 && load_fail_o == f0, "R2 status unchanged", {load_ok_o, load_fail_o}, {ok0, f0});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 0; start_i = 0; mode_i = 0; byte_count_i = 0; s_data_i = 0;
        s_valid_i = 0; nstatus_i = 1; conf_done_i = 0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(nconfig_o && !dclk_o && data_o == 0 && !busy_o && !s_ready_o && !load_ok_o && !load_fail_o && !abort_o,
            "R1 reset state", {nconfig_o, dclk_o, busy_o, load_ok_o, load_fail_o}, 16);
        rst_n = 1;
        @(negedge clk);
        for (int m = 0; m < 3; m++) begin
            run_load(m, 1, 1, -1, 0);
            run_load(m, 3, 1, -1, 1);
            run_load(m, 5, 1, -1, 0);
        end
        run_load(1, 2, 0, -1, 0);
        try_bad(3, 2);
        try_bad(0, 0);
        run_load(0, 4, 1, 2, 0);
        run_load(2, 3, 1, 0, 0);
        run_load(2, 2, 1, -1, 0);
        try_bad(1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule